// File: doc/BRIEF.md
# Flash Parameter Table Reader

This block walks a parallel NOR flash through its common flash query table and leaves the device's geometry and timing parameters in registers. After a start pulse it writes the query-entry command and reads back a three-character signature. It then collects the extended-table pointer, the eight timeout bytes, the device size, the write-buffer size, the erase-region count and one four-byte descriptor per region. The number of descriptors it reads depends on the count it has just read. At the end it writes the read-array command so the flash is usable again.

Every flash access goes out as a single-cycle request on a generic cycle-request port. The request is held until the external bus controller acknowledges it. A read's data arrives in the cycle of the acknowledge. If the signature is wrong the engine still restores read-array mode. In that case it reports an error and leaves every parameter register at zero. A region count of one marks the part as uniformly sectored, and a count above one marks it as boot-sectored.

Top module: `cfi_query_engine`

## Requirements
- R1: The first request after an accepted start is a write of 98h to address 55h. Every request holds address, direction and write data stable until the cycle it is acknowledged.
- R2: Addresses 10h, 11h and 12h are read in that order and must return 51h, 52h and 59h. The first mismatch ends the reads: the next request is the exit write, `error` is set, and all parameter outputs read zero.
- R3: `ext_table_ptr` holds the bytes read at 15h (bits 7:0) and 16h (bits 15:8).
- R4: `timeout_bytes` holds the bytes read at 1Fh through 26h, with the byte at 1Fh in bits 7:0 and each following address one byte higher.
- R5: `dev_size_log2` holds the byte read at 27h, and `wbuf_log2` holds the byte read at 2Ah.
- R6: `region_count` holds the raw byte read at 2Ch. Exactly min(count, MAX_REGIONS) descriptors are then read, four bytes each, in ascending address order from 2Dh + 4*i. Reads occur in the order 10h–12h, 15h–16h, 1Fh–26h, 27h, 2Ah, 2Ch, then the descriptors.
- R7: Descriptor i drives `region_blocks_m1[16*i+:16]` = {byte at 2Eh+4i, byte at 2Dh+4i} and `region_size_256[16*i+:16]` = {byte at 30h+4i, byte at 2Fh+4i}. Descriptors that are not read stay zero.
- R8: `uniform` is 1 exactly when `region_count` is 1. `boot` is 1 exactly when `region_count` is above 1.
- R9: The last request of every run is a write of F0h to address 00h. `done` rises in the cycle after that write is acknowledged, and `busy` then stays low until the next start.
- R10: After reset the engine is idle: no request, `busy`, `done` and `error` all low, and every parameter output zero.
- R11: A start pulse while busy has no effect on the request sequence. A start while idle or done clears all results and begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a query run |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished; results valid |
| error | output | 1 | Signature mismatch seen |
| req_valid | output | 1 | Flash cycle requested |
| req_write | output | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | output | AW | Flash address of the cycle |
| req_wdata | output | 8 | Write data |
| req_ack | input | 1 | Cycle completed this clock |
| rsp_rdata | input | 8 | Read data, valid with req_ack |
| ext_table_ptr | output | 16 | Extended table pointer |
| timeout_bytes | output | 64 | Eight timeout bytes |
| dev_size_log2 | output | 8 | Device size exponent |
| wbuf_log2 | output | 8 | Write-buffer size exponent |
| region_count | output | 8 | Raw erase-region count |
| uniform | output | 1 | Single erase region |
| boot | output | 1 | More than one erase region |
| region_blocks_m1 | output | 16*MAX_REGIONS | Per-region block count minus one |
| region_size_256 | output | 16*MAX_REGIONS | Per-region block size in 256-byte units |

## Verification
A captured byte appears on its output in the cycle after the edge that samples `req_ack` with it. The next request appears in that same cycle. `done` rises one edge after the exit write's acknowledge. The first request appears one edge after `start` is sampled.

The bench's flash model drives acknowledges and samples everything on falling clock edges, half a cycle away from the capturing edge. It compares each request against a list built from the region count and the injected fault before the run. All parameter outputs are checked once `done` is seen. Runs with different acknowledge latencies (one to three cycles) check that results do not depend on latency, only on the acknowledged order.

// File: rtl/cfi_qry_pkg.sv
package cfi_qry_pkg;

  typedef enum logic [3:0] {
    PH_IDLE, PH_ENTER, PH_SIG, PH_EXT, PH_TMO,
    PH_SIZE, PH_WBUF, PH_CNT, PH_REG, PH_EXIT, PH_DONE
  } phase_t;

  localparam logic [7:0] CMD_QUERY  = 8'h98;
  localparam logic [7:0] CMD_ARRAY  = 8'hF0;
  localparam logic [7:0] QUERY_ADDR = 8'h55;
  localparam logic [7:0] ARRAY_ADDR = 8'h00;

  // table address visited in a phase at step idx
  function automatic logic [7:0] step_addr(phase_t ph, int unsigned idx);
    case (ph)
      PH_ENTER: return QUERY_ADDR;
      PH_SIG:   return 8'(32'h10 + idx);
      PH_EXT:   return 8'(32'h15 + idx);
      PH_TMO:   return 8'(32'h1F + idx);
      PH_SIZE:  return 8'h27;
      PH_WBUF:  return 8'h2A;
      PH_CNT:   return 8'h2C;
      PH_REG:   return 8'(32'h2D + idx);
      default:  return ARRAY_ADDR;
    endcase
  endfunction

  function automatic logic [7:0] cmd_byte(phase_t ph);
    case (ph)
      PH_ENTER: return CMD_QUERY;
      PH_EXIT:  return CMD_ARRAY;
      default:  return 8'h00;
    endcase
  endfunction

  // expected signature character at position idx
  function automatic logic [7:0] sig_char(int unsigned idx);
    case (idx)
      0:       return 8'h51;
      1:       return 8'h52;
      default: return 8'h59;
    endcase
  endfunction

  function automatic int unsigned clamp_regions(logic [7:0] cnt, int unsigned lim);
    return (int'(cnt) > int'(lim)) ? lim : int'(cnt);
  endfunction

endpackage

// File: rtl/cfi_qry_sequencer.sv
module cfi_qry_sequencer
  import cfi_qry_pkg::*;
#(
  parameter int MAX_REGIONS = 4,
  parameter int IDXW = 4,
  parameter int NRW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            req_ack,
  input  logic [7:0]      rsp_rdata,
  output phase_t          phase,
  output logic [IDXW-1:0] idx,
  output logic            start_ok,
  output logic            step_fire,
  output logic            sig_bad,
  output logic            err
);

  logic            in_req;
  logic [NRW-1:0]  nreg_q;
  logic [NRW-1:0]  cnt_clamped;
  logic [IDXW-1:0] reg_last;

  always_comb begin
    in_req      = !(phase == PH_IDLE || phase == PH_DONE);
    step_fire   = in_req && req_ack;
    start_ok    = start && !in_req;
    sig_bad     = (phase == PH_SIG) && (rsp_rdata != sig_char(int'(idx)));
    cnt_clamped = NRW'(clamp_regions(rsp_rdata, MAX_REGIONS));
    reg_last    = IDXW'(4 * int'(nreg_q) - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      idx    <= '0;
      err    <= 1'b0;
      nreg_q <= '0;
    end else if (start_ok) begin
      phase  <= PH_ENTER;
      idx    <= '0;
      err    <= 1'b0;
      nreg_q <= '0;
    end else if (step_fire) begin
      case (phase)
        PH_ENTER: begin phase <= PH_SIG; idx <= '0; end
        PH_SIG: begin
          if (sig_bad) begin
            err   <= 1'b1;
            phase <= PH_EXIT;
          end else if (idx == IDXW'(2)) begin
            phase <= PH_EXT;
            idx   <= '0;
          end else idx <= idx + 1'b1;
        end
        PH_EXT: begin
          if (idx == IDXW'(1)) begin phase <= PH_TMO; idx <= '0; end
          else idx <= idx + 1'b1;
        end
        PH_TMO: begin
          if (idx == IDXW'(7)) begin phase <= PH_SIZE; idx <= '0; end
          else idx <= idx + 1'b1;
        end
        PH_SIZE: phase <= PH_WBUF;
        PH_WBUF: phase <= PH_CNT;
        PH_CNT: begin
          nreg_q <= cnt_clamped;
          idx    <= '0;
          phase  <= (cnt_clamped == '0) ? PH_EXIT : PH_REG;
        end
        PH_REG: begin
          if (idx == reg_last) phase <= PH_EXIT;
          else idx <= idx + 1'b1;
        end
        PH_EXIT: phase <= PH_DONE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfi_qry_store.sv
module cfi_qry_store
  import cfi_qry_pkg::*;
#(
  parameter int MAX_REGIONS = 4,
  parameter int IDXW = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic                      fire,
  input  phase_t                    phase,
  input  logic [IDXW-1:0]           idx,
  input  logic [7:0]                rdata,
  output logic [15:0]               ext_ptr,
  output logic [63:0]               tmo,
  output logic [7:0]                dsz,
  output logic [7:0]                wbl,
  output logic [7:0]                rcnt,
  output logic [16*MAX_REGIONS-1:0] blk_m1,
  output logic [16*MAX_REGIONS-1:0] blk_sz
);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      ext_ptr <= '0;
      tmo     <= '0;
      dsz     <= '0;
      wbl     <= '0;
      rcnt    <= '0;
    end else if (fire) begin
      case (phase)
        PH_EXT:  ext_ptr[idx[0]*8 +: 8] <= rdata;
        PH_TMO:  tmo[idx[2:0]*8 +: 8]   <= rdata;
        PH_SIZE: dsz  <= rdata;
        PH_WBUF: wbl  <= rdata;
        PH_CNT:  rcnt <= rdata;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < MAX_REGIONS; g++) begin : g_region
    logic [15:0] m1_q, sz_q;
    logic        hit;
    assign hit = fire && (phase == PH_REG) && (idx[IDXW-1:2] == (IDXW-2)'(g));
    always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
        m1_q <= '0;
        sz_q <= '0;
      end else if (hit) begin
        case (idx[1:0])
          2'd0: m1_q[7:0]  <= rdata;
          2'd1: m1_q[15:8] <= rdata;
          2'd2: sz_q[7:0]  <= rdata;
          default: sz_q[15:8] <= rdata;
        endcase
      end
    end
    assign blk_m1[16*g +: 16] = m1_q;
    assign blk_sz[16*g +: 16] = sz_q;
  end

endmodule

// File: rtl/cfi_query_engine.sv
module cfi_query_engine
  import cfi_qry_pkg::*;
#(
  parameter int MAX_REGIONS = 4,
  parameter int AW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  output logic                      busy,
  output logic                      done,
  output logic                      error,
  output logic                      req_valid,
  output logic                      req_write,
  output logic [AW-1:0]             req_addr,
  output logic [7:0]                req_wdata,
  input  logic                      req_ack,
  input  logic [7:0]                rsp_rdata,
  output logic [15:0]               ext_table_ptr,
  output logic [63:0]               timeout_bytes,
  output logic [7:0]                dev_size_log2,
  output logic [7:0]                wbuf_log2,
  output logic [7:0]                region_count,
  output logic                      uniform,
  output logic                      boot,
  output logic [16*MAX_REGIONS-1:0] region_blocks_m1,
  output logic [16*MAX_REGIONS-1:0] region_size_256
);

  localparam int REG_STEPS = 4 * MAX_REGIONS;
  localparam int IDXW = $clog2(REG_STEPS > 8 ? REG_STEPS : 8);
  localparam int NRW  = $clog2(MAX_REGIONS + 1);

  phase_t          phase;
  logic [IDXW-1:0] idx;
  logic            start_ok;
  logic            step_fire;
  logic            sig_bad;
  logic            err_q;

  cfi_qry_sequencer #(.MAX_REGIONS(MAX_REGIONS), .IDXW(IDXW), .NRW(NRW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .req_ack(req_ack),
    .rsp_rdata(rsp_rdata), .phase(phase), .idx(idx), .start_ok(start_ok),
    .step_fire(step_fire), .sig_bad(sig_bad), .err(err_q)
  );

  cfi_qry_store #(.MAX_REGIONS(MAX_REGIONS), .IDXW(IDXW)) u_store (
    .clk(clk), .rst_n(rst_n), .clear(start_ok), .fire(step_fire),
    .phase(phase), .idx(idx), .rdata(rsp_rdata),
    .ext_ptr(ext_table_ptr), .tmo(timeout_bytes), .dsz(dev_size_log2),
    .wbl(wbuf_log2), .rcnt(region_count),
    .blk_m1(region_blocks_m1), .blk_sz(region_size_256)
  );

  always_comb begin
    busy      = !(phase == PH_IDLE || phase == PH_DONE);
    done      = (phase == PH_DONE);
    error     = err_q;
    req_valid = busy;
    req_write = (phase == PH_ENTER) || (phase == PH_EXIT);
    req_addr  = AW'(step_addr(phase, int'(idx)));
    req_wdata = cmd_byte(phase);
    uniform   = (region_count == 8'd1);
    boot      = (region_count > 8'd1);
  end

endmodule

// File: rtl/cfi_qry_checker.sv
module cfi_qry_checker #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          error,
  input logic          req_valid,
  input logic          req_ack,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [7:0]    req_wdata,
  input logic [7:0]    dev_size_log2,
  input logic [7:0]    wbuf_log2,
  input logic [7:0]    region_count,
  input logic          uniform,
  input logic          boot,
  input logic          step_fire
);

  p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ack |=> req_valid && $stable(req_addr) && $stable(req_write) && $stable(req_wdata));

  p_err_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> dev_size_log2 == 8'd0 && wbuf_log2 == 8'd0 && region_count == 8'd0);

  p_class_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(uniform && boot));

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid && !busy);

  p_fire_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |-> busy && req_valid);

  p_exit_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(req_write) && $past(req_wdata) == 8'hF0 && $past(req_ack));

  p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !req_ack |=> busy);

endmodule

bind cfi_query_engine cfi_qry_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .error(error), .req_valid(req_valid), .req_ack(req_ack),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .dev_size_log2(dev_size_log2), .wbuf_log2(wbuf_log2),
  .region_count(region_count), .uniform(uniform), .boot(boot),
  .step_fire(step_fire)
);

// File: tb/test_cfi_query_engine.sv
module test_cfi_query_engine;

  localparam int MAXR = 4;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, error, req_valid, req_write, uniform, boot;
  logic [AW-1:0] req_addr;
  logic [7:0] req_wdata, dev_size_log2, wbuf_log2, region_count;
  logic req_ack = 1'b0;
  logic [7:0] rsp_rdata = 8'h00;
  logic [15:0] ext_table_ptr;
  logic [63:0] timeout_bytes;
  logic [16*MAXR-1:0] region_blocks_m1, region_size_256;

  cfi_query_engine #(.MAX_REGIONS(MAXR), .AW(AW)) i_cfi_query_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .error(error), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
    .rsp_rdata(rsp_rdata), .ext_table_ptr(ext_table_ptr),
    .timeout_bytes(timeout_bytes), .dev_size_log2(dev_size_log2),
    .wbuf_log2(wbuf_log2), .region_count(region_count), .uniform(uniform),
    .boot(boot), .region_blocks_m1(region_blocks_m1),
    .region_size_256(region_size_256)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  // run configuration read by the flash model
  int run_id = 0;
  int cnt_byte = 0;
  int err_pos = -1;
  int lat_lim = 1;

  // expected request list
  logic       ex_w[64];
  logic [7:0] ex_a[64];
  logic [7:0] ex_d[64];
  int n_exp = 0;

  // model state
  logic qmode = 1'b0;
  int n_req = 0;
  int seq_bad = 0;
  int lat = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] tbl(int a);
    if (a >= 'h10 && a <= 'h12) begin
      logic [7:0] c;
      c = (a == 'h10) ? 8'h51 : (a == 'h11) ? 8'h52 : 8'h59;
      if (err_pos == a - 'h10) c = c ^ 8'h20;
      return c;
    end
    if (a == 'h2C) return 8'(cnt_byte);
    return 8'(a * 7 + run_id * 13 + 1);
  endfunction

  task automatic add_exp(logic w, int a, logic [7:0] d);
    ex_w[n_exp] = w;
    ex_a[n_exp] = 8'(a);
    ex_d[n_exp] = d;
    n_exp++;
  endtask

  task automatic build_exp();
    int nr;
    n_exp = 0;
    add_exp(1'b1, 'h55, 8'h98);
    for (int i = 0; i < 3; i++) begin
      add_exp(1'b0, 'h10 + i, 8'h00);
      if (err_pos == i) begin
        add_exp(1'b1, 'h00, 8'hF0);
        return;
      end
    end
    add_exp(1'b0, 'h15, 8'h00);
    add_exp(1'b0, 'h16, 8'h00);
    for (int i = 0; i < 8; i++) add_exp(1'b0, 'h1F + i, 8'h00);
    add_exp(1'b0, 'h27, 8'h00);
    add_exp(1'b0, 'h2A, 8'h00);
    add_exp(1'b0, 'h2C, 8'h00);
    nr = (cnt_byte > MAXR) ? MAXR : cnt_byte;
    for (int i = 0; i < 4 * nr; i++) add_exp(1'b0, 'h2D + i, 8'h00);
    add_exp(1'b1, 'h00, 8'hF0);
  endtask

  // flash model: acts on falling edges only
  always @(negedge clk) begin
    if (req_ack) begin
      req_ack = 1'b0;
      lat = 0;
    end else if (req_valid) begin
      lat++;
      if (lat >= lat_lim) begin
        if (n_req >= n_exp || req_write !== ex_w[n_req] || req_addr !== ex_a[n_req] ||
            (req_write && req_wdata !== ex_d[n_req]))
          seq_bad++;
        if (req_write) begin
          if (req_addr == 8'h55 && req_wdata == 8'h98) qmode = 1'b1;
          if (req_wdata == 8'hF0) qmode = 1'b0;
          rsp_rdata = 8'h00;
        end else begin
          rsp_rdata = qmode ? tbl(int'(req_addr)) : 8'hEE;
        end
        req_ack = 1'b1;
        n_req++;
      end
    end
  end

  task automatic do_run(int rid, int cnt, int ep);
    int nr;
    logic [63:0] tmo_e;
    run_id = rid;
    cnt_byte = cnt;
    err_pos = ep;
    lat_lim = 1 + rid % 3;
    build_exp();
    n_req = 0;
    seq_bad = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (6) @(negedge clk);
    start = 1'b1;                 // R11: pulse while busy
    @(negedge clk) start = 1'b0;
    while (!done) @(negedge clk);
    nr = (ep >= 0) ? 0 : ((cnt > MAXR) ? MAXR : cnt);
    // R1, R6, R9: request sequence and count
    chk($sformatf("R6 run%0d request order mismatches", rid), 64'(seq_bad), 64'd0);
    chk($sformatf("R11 run%0d request count", rid), 64'(n_req), 64'(n_exp));
    chk($sformatf("R9 run%0d flash back in array mode", rid), 64'(qmode), 64'd0);
    chk($sformatf("R9 run%0d busy low at done", rid), 64'(busy), 64'd0);
    chk($sformatf("R2 run%0d error flag", rid), 64'(error), (ep >= 0) ? 64'd1 : 64'd0);
    if (ep >= 0) begin
      chk($sformatf("R2 run%0d params zero", rid),
          {ext_table_ptr, dev_size_log2, wbuf_log2, region_count} | timeout_bytes, 64'd0);
    end else begin
      chk($sformatf("R3 run%0d ext pointer", rid), 64'(ext_table_ptr), {48'd0, tbl('h16), tbl('h15)});
      tmo_e = '0;
      for (int i = 0; i < 8; i++) tmo_e[8*i +: 8] = tbl('h1F + i);
      chk($sformatf("R4 run%0d timeouts", rid), timeout_bytes, tmo_e);
      chk($sformatf("R5 run%0d device size", rid), 64'(dev_size_log2), 64'(tbl('h27)));
      chk($sformatf("R5 run%0d write buffer", rid), 64'(wbuf_log2), 64'(tbl('h2A)));
      chk($sformatf("R6 run%0d region count", rid), 64'(region_count), 64'(cnt));
    end
    for (int i = 0; i < MAXR; i++) begin
      logic [15:0] m1, sz;
      m1 = (i < nr) ? {tbl('h2E + 4 * i), tbl('h2D + 4 * i)} : 16'h0;
      sz = (i < nr) ? {tbl('h30 + 4 * i), tbl('h2F + 4 * i)} : 16'h0;
      chk($sformatf("R7 run%0d region%0d blocks", rid, i), 64'(region_blocks_m1[16*i +: 16]), 64'(m1));
      chk($sformatf("R7 run%0d region%0d size", rid, i), 64'(region_size_256[16*i +: 16]), 64'(sz));
    end
    chk($sformatf("R8 run%0d uniform", rid), 64'(uniform), (ep < 0 && cnt == 1) ? 64'd1 : 64'd0);
    chk($sformatf("R8 run%0d boot", rid), 64'(boot), (ep < 0 && cnt > 1) ? 64'd1 : 64'd0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk("R10 idle flags", {61'd0, busy, done, error}, 64'd0);
    chk("R10 no request", 64'(req_valid), 64'd0);
    chk("R10 params zero",
        {ext_table_ptr, dev_size_log2, wbuf_log2, region_count} | timeout_bytes |
        region_blocks_m1 | region_size_256, 64'd0);
    for (int c = 0; c <= 6; c++) do_run(c, c, -1);
    do_run(7, 255, -1);
    for (int p = 0; p < 3; p++) do_run(8 + p, 3, p);
    do_run(11, 2, -1);
    summary();
  end

endmodule